// File: doc/BRIEF.md
# DDR3 Column Command Spacing Monitor

This block watches the column commands on a DDR3-style command bus, one command slot per clock. For every READ or WRITE it decides whether the access is an 8-beat burst or a 4-beat chop. It reports that choice one cycle later. It also predicts the clock periods in which read or write data will be on the data bus and drives a strobe for each direction during those periods.

Alongside this it measures the distance, in clocks, from the most recent READ to each new READ or WRITE. When a command arrives earlier than the spacing rules allow, it raises a one-cycle violation pulse for that command type and sets a matching sticky flag, which stays set until reset. The burst-mode field, the CAS latency, the CAS write latency and the additive latency are static configuration inputs. The minimum column-to-column spacing is a parameter.

Top module: `ddr3_col_spacing_mon`

## Requirements
- R1: With burst-mode field `mode_bl_i` = 2'b00, every decoded READ or WRITE is an 8-beat burst: `col_vld_o` and `bl8_o` are both 1 in the cycle after the command edge.
- R2: With `mode_bl_i` = 2'b10, every decoded READ or WRITE is a 4-beat chop: `col_vld_o` is 1 and `bl8_o` is 0 in the cycle after the command edge.
- R3: With `mode_bl_i` = 2'b01, the burst is chosen per command from `a12_i` sampled with it: 1 gives an 8-beat burst and 0 gives a 4-beat chop.
- R4: With `mode_bl_i` = 2'b11, `cfg_err_o` is 1 in the cycle after each edge where it is sampled. Commands sampled under that mode are ignored: no `col_vld_o`, no data window, no violation, and no change to the read-spacing history.
- R5: A READ decoded at edge k drives `rd_win_o` high for the periods after edges k+RL through k+RL+N-1. Here RL = `cas_lat_i` + `add_lat_i`, and N is 4 for an 8-beat burst and 2 for a 4-beat chop.
- R6: A WRITE decoded at edge k drives `wr_win_o` high for the periods after edges k+WL through k+WL+N-1. Here WL = `cas_wlat_i` + `add_lat_i` and N is as in R5.
- R7: A READ whose distance from the previous decoded READ is less than TCCD clocks gives a one-cycle `rr_viol_o` pulse in the next cycle and sets `rr_err_o`. `rr_err_o` stays set until reset.
- R8: A WRITE whose distance from the previous decoded READ is less than RL + TCCD + 2 - WL clocks gives a one-cycle `rw_viol_o` pulse in the next cycle and sets `rw_err_o`. `rw_err_o` stays set until reset.
- R9: Synchronous active-high `rst` clears all outputs, flags and pending windows. After reset, the first READ or WRITE is never a violation.
- R10: The command encoding on `cmd_i` is 2'b00 no operation, 2'b01 READ, 2'b10 WRITE. The value 2'b11 is treated as no operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 2 | Column command of this slot (R10 encoding) |
| a12_i | input | 1 | Per-command burst select bit |
| mode_bl_i | input | 2 | Burst-mode configuration field |
| cas_lat_i | input | LAT_W | CAS latency in clocks |
| cas_wlat_i | input | LAT_W | CAS write latency in clocks |
| add_lat_i | input | LAT_W | Additive latency in clocks |
| col_vld_o | output | 1 | A column command was decoded at the previous edge |
| bl8_o | output | 1 | That command is an 8-beat burst |
| rd_win_o | output | 1 | Read data expected on the bus this period |
| wr_win_o | output | 1 | Write data expected on the bus this period |
| rr_viol_o | output | 1 | READ-to-READ spacing violation pulse |
| rw_viol_o | output | 1 | READ-to-WRITE spacing violation pulse |
| rr_err_o | output | 1 | Sticky READ-to-READ violation flag |
| rw_err_o | output | 1 | Sticky READ-to-WRITE violation flag |
| cfg_err_o | output | 1 | Reserved burst mode was sampled |

## Verification
The hardest case to reach is a READ issued under the reserved mode that falls between two legal READs. If that READ wrongly updated the spacing history, the only visible effect would be a false violation on the later READ. The stimulus issues a READ, switches to the reserved mode for a READ two clocks later, then restores fixed 8-beat mode and issues a READ exactly TCCD clocks after the first one. The latency-dependent READ-to-WRITE bound is covered by changing the additive and write latencies during the run and placing WRITEs one clock inside and exactly on the recomputed bound.

// File: rtl/ddr3_csm_pkg.sv
package ddr3_csm_pkg;

  typedef enum logic [1:0] {
    CMD_NOP = 2'b00,
    CMD_RD  = 2'b01,
    CMD_WR  = 2'b10,
    CMD_RSV = 2'b11
  } col_cmd_e;

  localparam logic [1:0] BLM_FIX8 = 2'b00;
  localparam logic [1:0] BLM_OTF  = 2'b01;
  localparam logic [1:0] BLM_FIX4 = 2'b10;
  localparam logic [1:0] BLM_RSV  = 2'b11;

  // data transfers twice per clock: 8 beats -> 4 clocks, 4 beats -> 2 clocks
  localparam int unsigned SLOT_CLK = 4;

  function automatic logic pick_bl8(input logic [1:0] mode, input logic sel);
    case (mode)
      BLM_FIX8: pick_bl8 = 1'b1;
      BLM_OTF:  pick_bl8 = sel;
      default:  pick_bl8 = 1'b0;
    endcase
  endfunction

  function automatic int burst_clocks(input logic bl8);
    burst_clocks = bl8 ? 4 : 2;
  endfunction

  // minimum READ->WRITE distance; may be zero or negative
  function automatic int rd_to_wr_min(input int rl, input int wl, input int tccd);
    rd_to_wr_min = rl + tccd + 2 - wl;
  endfunction

endpackage

// File: rtl/ddr3_csm_decode.sv
module ddr3_csm_decode
  import ddr3_csm_pkg::*;
(
  input  logic [1:0] cmd,
  input  logic       sel,
  input  logic [1:0] mode,
  output logic       rd_ev,
  output logic       wr_ev,
  output logic       bl8,
  output logic       cfg_bad
);

  always_comb begin
    cfg_bad = (mode == BLM_RSV);
    rd_ev   = (cmd == CMD_RD) && !cfg_bad;
    wr_ev   = (cmd == CMD_WR) && !cfg_bad;
    bl8     = pick_bl8(mode, sel);
  end

endmodule

// File: rtl/ddr3_csm_win.sv
module ddr3_csm_win
  import ddr3_csm_pkg::*;
#(
  parameter int LAT_W = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           fire,
  input  logic [LAT_W:0] lat,
  input  logic           bl8,
  output logic           win_o
);

  localparam int SW = (1 << (LAT_W + 1)) + SLOT_CLK;

  logic [SW-1:0] sched_q;
  logic [SW-1:0] mask;

  // bit i of the schedule after edge k marks the period after edge k+i
  always_comb begin
    for (int i = 0; i < SW; i++) begin
      mask[i] = fire && (i >= int'(lat)) && (i < int'(lat) + burst_clocks(bl8));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sched_q <= '0;
    else     sched_q <= (sched_q >> 1) | mask;
  end

  assign win_o = sched_q[0];

endmodule

// File: rtl/ddr3_csm_gap.sv
module ddr3_csm_gap
  import ddr3_csm_pkg::*;
#(
  parameter int LAT_W = 4,
  parameter int CNT_W = 6,
  parameter int TCCD  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_ev,
  input  logic             wr_ev,
  input  logic [LAT_W:0]   rl,
  input  logic [LAT_W:0]   wl,
  output logic             rr_hit,
  output logic             rw_hit,
  output logic [CNT_W-1:0] gap_o
);

  localparam logic [CNT_W-1:0] GAP_SAT = '1;

  logic [CNT_W-1:0] gap_q;

  // distance since the last decoded READ; saturates, starts satisfied
  always_ff @(posedge clk) begin
    if (rst)                  gap_q <= GAP_SAT;
    else if (rd_ev)           gap_q <= CNT_W'(1);
    else if (gap_q != GAP_SAT) gap_q <= gap_q + CNT_W'(1);
  end

  always_comb begin
    rr_hit = rd_ev && (int'(gap_q) < TCCD);
    rw_hit = wr_ev && (int'(gap_q) < rd_to_wr_min(int'(rl), int'(wl), TCCD));
  end

  assign gap_o = gap_q;

endmodule

// File: rtl/ddr3_col_spacing_mon.sv
module ddr3_col_spacing_mon
  import ddr3_csm_pkg::*;
#(
  parameter int LAT_W = 4,
  parameter int CNT_W = 6,
  parameter int TCCD  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cmd_i,
  input  logic             a12_i,
  input  logic [1:0]       mode_bl_i,
  input  logic [LAT_W-1:0] cas_lat_i,
  input  logic [LAT_W-1:0] cas_wlat_i,
  input  logic [LAT_W-1:0] add_lat_i,
  output logic             col_vld_o,
  output logic             bl8_o,
  output logic             rd_win_o,
  output logic             wr_win_o,
  output logic             rr_viol_o,
  output logic             rw_viol_o,
  output logic             rr_err_o,
  output logic             rw_err_o,
  output logic             cfg_err_o
);

  logic           rd_ev, wr_ev, dec_bl8, cfg_bad;
  logic           rr_hit, rw_hit;
  logic [CNT_W-1:0] rd_gap;
  logic [LAT_W:0] rl, wl;

  assign rl = {1'b0, cas_lat_i}  + {1'b0, add_lat_i};
  assign wl = {1'b0, cas_wlat_i} + {1'b0, add_lat_i};

  ddr3_csm_decode u_dec (
    .cmd(cmd_i), .sel(a12_i), .mode(mode_bl_i),
    .rd_ev(rd_ev), .wr_ev(wr_ev), .bl8(dec_bl8), .cfg_bad(cfg_bad)
  );

  ddr3_csm_win #(.LAT_W(LAT_W)) u_rd_win (
    .clk(clk), .rst(rst), .fire(rd_ev), .lat(rl), .bl8(dec_bl8), .win_o(rd_win_o)
  );

  ddr3_csm_win #(.LAT_W(LAT_W)) u_wr_win (
    .clk(clk), .rst(rst), .fire(wr_ev), .lat(wl), .bl8(dec_bl8), .win_o(wr_win_o)
  );

  ddr3_csm_gap #(.LAT_W(LAT_W), .CNT_W(CNT_W), .TCCD(TCCD)) u_gap (
    .clk(clk), .rst(rst), .rd_ev(rd_ev), .wr_ev(wr_ev), .rl(rl), .wl(wl),
    .rr_hit(rr_hit), .rw_hit(rw_hit), .gap_o(rd_gap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      col_vld_o <= 1'b0;
      bl8_o     <= 1'b0;
      rr_viol_o <= 1'b0;
      rw_viol_o <= 1'b0;
      rr_err_o  <= 1'b0;
      rw_err_o  <= 1'b0;
      cfg_err_o <= 1'b0;
    end else begin
      col_vld_o <= rd_ev | wr_ev;
      bl8_o     <= (rd_ev | wr_ev) & dec_bl8;
      rr_viol_o <= rr_hit;
      rw_viol_o <= rw_hit;
      rr_err_o  <= rr_err_o | rr_hit;
      rw_err_o  <= rw_err_o | rw_hit;
      cfg_err_o <= cfg_bad;
    end
  end

endmodule

// File: rtl/ddr3_csm_chk.sv
module ddr3_csm_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] cmd_i,
  input logic [1:0] mode_bl_i,
  input logic       col_vld_o,
  input logic       bl8_o,
  input logic       rr_viol_o,
  input logic       rw_viol_o,
  input logic       rr_err_o,
  input logic       rw_err_o,
  input logic       cfg_err_o
);

  a_r1_fixed_eight: assert property (@(posedge clk) disable iff (rst)
    (mode_bl_i == 2'b00 && (cmd_i == 2'b01 || cmd_i == 2'b10)) |=> (col_vld_o && bl8_o));

  a_r2_fixed_chop: assert property (@(posedge clk) disable iff (rst)
    (mode_bl_i == 2'b10 && (cmd_i == 2'b01 || cmd_i == 2'b10)) |=> (col_vld_o && !bl8_o));

  a_r4_reserved_quiet: assert property (@(posedge clk) disable iff (rst)
    (mode_bl_i == 2'b11) |=> (cfg_err_o && !col_vld_o && !rr_viol_o && !rw_viol_o));

  a_r7_rr_sticky_set: assert property (@(posedge clk) disable iff (rst)
    rr_viol_o |-> rr_err_o);

  a_r7_rr_sticky_hold: assert property (@(posedge clk) disable iff (rst)
    rr_err_o |=> rr_err_o);

  a_r8_rw_sticky_set: assert property (@(posedge clk) disable iff (rst)
    rw_viol_o |-> rw_err_o);

  a_r8_rw_sticky_hold: assert property (@(posedge clk) disable iff (rst)
    rw_err_o |=> rw_err_o);

  a_r10_nop_code: assert property (@(posedge clk) disable iff (rst)
    (cmd_i == 2'b11 || cmd_i == 2'b00) |=> !col_vld_o);

endmodule

bind ddr3_col_spacing_mon ddr3_csm_chk u_chk (
  .clk(clk), .rst(rst), .cmd_i(cmd_i), .mode_bl_i(mode_bl_i),
  .col_vld_o(col_vld_o), .bl8_o(bl8_o), .rr_viol_o(rr_viol_o), .rw_viol_o(rw_viol_o),
  .rr_err_o(rr_err_o), .rw_err_o(rw_err_o), .cfg_err_o(cfg_err_o)
);

// File: tb/ddr3_col_spacing_mon_tb.sv
module ddr3_col_spacing_mon_tb_top;

  localparam int CLK_P = 10;
  localparam int LAT_W = 4;
  localparam int TCCD  = 4;
  localparam int HZ    = 1024;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [1:0]       cmd_i = 2'b00;
  logic             a12_i = 1'b0;
  logic [1:0]       mode_bl_i = 2'b00;
  logic [LAT_W-1:0] cas_lat_i = 4'd5;
  logic [LAT_W-1:0] cas_wlat_i = 4'd5;
  logic [LAT_W-1:0] add_lat_i = 4'd0;
  logic col_vld_o, bl8_o, rd_win_o, wr_win_o, rr_viol_o, rw_viol_o, rr_err_o, rw_err_o, cfg_err_o;

  always #(CLK_P/2) clk = ~clk;

  ddr3_col_spacing_mon #(.LAT_W(LAT_W), .CNT_W(6), .TCCD(TCCD)) dut_i (
    .clk(clk), .rst(rst), .cmd_i(cmd_i), .a12_i(a12_i), .mode_bl_i(mode_bl_i),
    .cas_lat_i(cas_lat_i), .cas_wlat_i(cas_wlat_i), .add_lat_i(add_lat_i),
    .col_vld_o(col_vld_o), .bl8_o(bl8_o), .rd_win_o(rd_win_o), .wr_win_o(wr_win_o),
    .rr_viol_o(rr_viol_o), .rw_viol_o(rw_viol_o), .rr_err_o(rr_err_o),
    .rw_err_o(rw_err_o), .cfg_err_o(cfg_err_o)
  );

  typedef struct { int edge_n; bit bl8; string req; } col_item_t;
  col_item_t exp_q[$];

  int  checks = 0, fails = 0, ecount = 0, last_rd = -1000;
  bit  exp_rd[HZ];
  bit  exp_wr[HZ];
  bit  exp_rrp, exp_rwp, exp_rre, exp_rwe, exp_cfg;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d (edge %0d)", req, what, act, exp, ecount);
    end
  endtask

  // monitor: compares every output against the scoreboard after each edge
  task automatic monitor();
    chk(rd_win_o == exp_rd[ecount], "R5", "rd_win_o", rd_win_o, exp_rd[ecount]);
    chk(wr_win_o == exp_wr[ecount], "R6", "wr_win_o", wr_win_o, exp_wr[ecount]);
    chk(rr_viol_o == exp_rrp, "R7", "rr_viol_o", rr_viol_o, exp_rrp);
    chk(rr_err_o == exp_rre, "R7", "rr_err_o", rr_err_o, exp_rre);
    chk(rw_viol_o == exp_rwp, "R8", "rw_viol_o", rw_viol_o, exp_rwp);
    chk(rw_err_o == exp_rwe, "R8", "rw_err_o", rw_err_o, exp_rwe);
    chk(cfg_err_o == exp_cfg, "R4", "cfg_err_o", cfg_err_o, exp_cfg);
    if (exp_q.size() > 0 && exp_q[0].edge_n == ecount) begin
      col_item_t it = exp_q.pop_front();
      chk(col_vld_o == 1'b1, it.req, "col_vld_o", col_vld_o, 1);
      chk(bl8_o == it.bl8, it.req, "bl8_o", bl8_o, it.bl8);
    end else begin
      chk(col_vld_o == 1'b0, "R10", "col_vld_o idle", col_vld_o, 0);
    end
  endtask

  // driver: applies one command slot and pushes its expected effects
  task automatic tick(input logic [1:0] c, input logic a);
    int e, rl, wl, len;
    bit dec, b8;
    string rq;
    cmd_i = c; a12_i = a;
    e  = ecount + 1;
    rl = int'(cas_lat_i) + int'(add_lat_i);
    wl = int'(cas_wlat_i) + int'(add_lat_i);
    dec = (c == 2'b01 || c == 2'b10) && mode_bl_i != 2'b11;
    b8  = (mode_bl_i == 2'b00) ? 1'b1 : (mode_bl_i == 2'b10) ? 1'b0 : a;
    rq  = (mode_bl_i == 2'b00) ? "R1" : (mode_bl_i == 2'b10) ? "R2" : "R3";
    len = b8 ? 4 : 2;
    exp_rrp = 0; exp_rwp = 0;
    if (dec) begin
      exp_q.push_back('{e, b8, rq});
      if (c == 2'b01) begin
        if (e - last_rd < TCCD) exp_rrp = 1;
        last_rd = e;
        for (int i = rl; i < rl + len; i++) exp_rd[e + i] = 1;
      end else begin
        if (e - last_rd < rl + TCCD + 2 - wl) exp_rwp = 1;
        for (int i = wl; i < wl + len; i++) exp_wr[e + i] = 1;
      end
    end
    exp_rre |= exp_rrp;
    exp_rwe |= exp_rwp;
    exp_cfg = (mode_bl_i == 2'b11);
    @(posedge clk); ecount++;
    @(negedge clk);
    monitor();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(2'b00, 1'b0);
  endtask

  task automatic do_reset();
    rst = 1'b1; cmd_i = 2'b00;
    repeat (2) begin @(posedge clk); ecount++; end
    @(negedge clk);
    rst = 1'b0;
    foreach (exp_rd[i]) begin exp_rd[i] = 0; exp_wr[i] = 0; end
    exp_q.delete();
    last_rd = -1000;
    exp_rrp = 0; exp_rwp = 0; exp_rre = 0; exp_rwe = 0; exp_cfg = 0;
    // R9: reset state
    chk({col_vld_o, bl8_o, rd_win_o, wr_win_o, rr_viol_o, rw_viol_o, rr_err_o, rw_err_o, cfg_err_o} == 9'd0,
        "R9", "outputs after reset",
        {col_vld_o, bl8_o, rd_win_o, wr_win_o, rr_viol_o, rw_viol_o, rr_err_o, rw_err_o, cfg_err_o}, 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R9: first command after reset is never a violation; R1/R5 8-beat read
    tick(2'b01, 1'b0); idle(12);
    tick(2'b10, 1'b0); idle(12);
    // R2 chop
    mode_bl_i = 2'b10;
    tick(2'b01, 1'b1); idle(10);
    tick(2'b10, 1'b1); idle(10);
    // R3 per-command selection
    mode_bl_i = 2'b01;
    tick(2'b10, 1'b1); idle(10);
    tick(2'b01, 1'b0); idle(10);
    tick(2'b01, 1'b1); idle(10);
    // R7 read-to-read: gap 4 legal, then chops at gap 3
    mode_bl_i = 2'b00;
    tick(2'b01, 1'b0); idle(3); tick(2'b01, 1'b0); idle(12);
    mode_bl_i = 2'b10;
    tick(2'b01, 1'b0); idle(2); tick(2'b01, 1'b0); idle(12);
    // R8 read-to-write, RL=5 WL=5: needs 6
    mode_bl_i = 2'b00;
    tick(2'b01, 1'b0); idle(5); tick(2'b10, 1'b0); idle(14);
    tick(2'b01, 1'b0); idle(4); tick(2'b10, 1'b0); idle(14);
    // R8 with RL=8 WL=7: needs 7
    cas_lat_i = 4'd6; cas_wlat_i = 4'd5; add_lat_i = 4'd2;
    tick(2'b01, 1'b0); idle(6); tick(2'b10, 1'b0); idle(16);
    tick(2'b01, 1'b0); idle(5); tick(2'b10, 1'b0); idle(16);
    cas_lat_i = 4'd5; cas_wlat_i = 4'd5; add_lat_i = 4'd0;
    // R4 reserved mode read does not count as the previous read
    tick(2'b01, 1'b0); tick(2'b00, 1'b0);
    mode_bl_i = 2'b11;
    tick(2'b01, 1'b1); tick(2'b10, 1'b1);
    mode_bl_i = 2'b00;
    tick(2'b01, 1'b0); idle(12);
    // R10 reserved command code acts as no operation
    tick(2'b11, 1'b1); idle(3);
    // R9 reset clears the sticky flags
    do_reset();
    tick(2'b10, 1'b0); idle(10);
    chk(exp_q.size() == 0, "R1", "pending scoreboard items", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule